// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Clock/Calendar Register File

This block lets a two-wire bus master reach an eight-entry register file: seven time-of-day and calendar bytes, plus one calibration/control byte. A fast system clock oversamples the bus. SCL and SDA pass through synchronisers. The block drives SDA only by asserting an open-drain pull-down enable. A bus transaction opens with START and the 7-bit device address 1101000; the address byte then reads D0h for a write and D1h for a read. After a write-address byte, the first data byte sets a three-bit word pointer. Every later byte is written at the pointer, and the pointer then moves up by one. A read returns bytes from the pointer onward. The pointer advances only when the master acknowledges a byte.

The time counters are outside this block. The block observes them through a 56-bit live bus, where byte i sits at bits 8i+7..8i. It keeps a readable snapshot of those bytes. While a read is in progress and the pointer sits on a time address, the snapshot stops following the live bus, so a multi-byte read returns a coherent time. Writes to time addresses leave the block as a one-cycle strobe with an address and a data byte, for the counter logic to load. The calibration byte is stored inside the block.

Top module: `rtcI2cRegs`

## Requirements
- R1: Only the address bytes D0h (write) and D1h (read) are acknowledged. After any other address byte, SDA stays released, and every byte up to the next START is ignored: nothing is acknowledged, written or moved.
- R2: In a write, the first data byte loads the pointer from its bits 2:0. Each later byte goes to the pointed location, and the pointer then steps by one, wrapping from 7 to 0. Locations 0 to 6 produce a one-cycle `wrEn` with `wrAddr` and `wrData`. Location 7 updates `calOut` and produces no `wrEn`.
- R3: In a write, the slave pulls SDA low during the ninth clock of the address byte, the pointer byte and every data byte.
- R4: In a read, data is sent MSB first. The pointer advances only when the master drives SDA low in the ninth clock. After a byte that the master does not acknowledge, SDA stays released until the next START.
- R5: A read that follows no pointer write begins at the location where the pointer was last left, including after an aborted or unacknowledged transfer.
- R6: The snapshot stops following the live bus from the read address byte until STOP, for as long as the pointer is between 0 and 6. It follows the live bus again while the pointer is 7. A later wrap to 0 returns the value captured at that point.
- R7: The following bits read back as 0 and are forced to 0 on writes: bits 7:6 of location 2, bits 7:3 of location 3, bits 7:6 of location 4, and bit 7 of location 7. All other bits pass through unchanged.
- R8: START is detected when SDA falls while SCL is high; STOP when SDA rises while SCL is high. A START at any time restarts address reception. A STOP returns the block to idle with SDA released. The slave changes SDA only while SCL is low.
- R9: After reset, SDA is released, `calOut` is 00h, no write strobe is active, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| liveTime | input | 56 | Live counter bytes, location i at bits 8i+7..8i |
| wrEn | output | 1 | One-cycle strobe: write a time location |
| wrAddr | output | 3 | Time location being written (0 to 6) |
| wrData | output | 8 | Written byte with zero-bits forced low |
| calOut | output | 8 | Stored calibration/control byte |

## Verification
The bench checks that an unacknowledged read byte leaves the pointer in place. A design that stepped on every byte would return the following location on the next current-address read. Live values are changed in the middle of a burst read, and all later bytes must still match the earlier value. A snapshot that never froze would mix old and new bytes. A snapshot that never thawed at location 7 would return stale data after the wrap to 0. A foreign address is followed by bytes that look like valid pointer and data writes. Any acknowledge or write strobe after it shows a block that failed to ignore the rest of the transaction.

// File: rtl/rtcI2cPkg.sv
package rtcI2cPkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_PTR, S_PTR_ACK,
    S_WR, S_WR_ACK, S_RD, S_RD_ACK, S_SKIP
  } busState_t;

  // strobes from control to datapath, each valid for one cycle
  typedef struct packed {
    logic loadPtr;
    logic wrByte;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
    logic beginRead;
    logic endRead;
  } ctlStrb_t;

  // bits that exist in each location; the rest read and write as zero
  function automatic logic [7:0] usedBits(input int idx);
    case (idx)
      2:       usedBits = 8'h3F;
      3:       usedBits = 8'h07;
      4:       usedBits = 8'h3F;
      7:       usedBits = 8'h7F;
      default: usedBits = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/rtcI2cSync.sv
module rtcI2cSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl  = sclPipe[STAGES-1];
  assign sdaLvl  = sdaPipe[STAGES-1];
  assign sclRise = sclLvl & ~sclPrev;
  assign sclFall = ~sclLvl & sclPrev;
  assign startEv = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopEv  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
endmodule

// File: rtl/rtcI2cCtrl.sv
module rtcI2cCtrl
  import rtcI2cPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sdaLvl,
  input  logic     sclRise,
  input  logic     sclFall,
  input  logic     startEv,
  input  logic     stopEv,
  input  logic     txBit,
  output ctlStrb_t strb,
  output logic [7:0] rxByte,
  output logic     sdaOe
);
  busState_t stateQ, stateD;
  logic [3:0] cntQ, cntD;
  logic [7:0] rxQ, rxD;
  logic isReadQ, isReadD;
  logic mAckQ, mAckD;

  always_comb begin
    stateD  = stateQ;
    cntD    = cntQ;
    rxD     = rxQ;
    isReadD = isReadQ;
    mAckD   = mAckQ;
    strb    = '0;
    if (stopEv) begin
      stateD = S_IDLE;
      strb.endRead = 1'b1;
    end else if (startEv) begin
      stateD = S_ADDR;
      cntD   = '0;
    end else begin
      case (stateQ)
        S_ADDR, S_PTR, S_WR: begin
          if (sclRise) begin
            rxD  = {rxQ[6:0], sdaLvl};
            cntD = cntQ + 4'd1;
          end else if (sclFall && cntQ == 4'd8) begin
            if (stateQ == S_ADDR) begin
              if (rxQ[7:1] == DEV_ADDR) begin
                stateD  = S_ADDR_ACK;
                isReadD = rxQ[0];
                strb.beginRead = rxQ[0];
              end else begin
                stateD = S_SKIP;
              end
            end else if (stateQ == S_PTR) begin
              stateD = S_PTR_ACK;
              strb.loadPtr = 1'b1;
            end else begin
              stateD = S_WR_ACK;
              strb.wrByte = 1'b1;
            end
          end
        end
        S_ADDR_ACK: if (sclFall) begin
          cntD = '0;
          if (isReadQ) begin
            stateD = S_RD;
            strb.loadTx = 1'b1;
          end else begin
            stateD = S_PTR;
          end
        end
        S_PTR_ACK, S_WR_ACK: if (sclFall) begin
          stateD = S_WR;
          cntD   = '0;
        end
        S_RD: if (sclFall) begin
          if (cntQ == 4'd7) begin
            stateD = S_RD_ACK;
          end else begin
            strb.shiftTx = 1'b1;
            cntD = cntQ + 4'd1;
          end
        end
        S_RD_ACK: begin
          if (sclRise) begin
            mAckD = ~sdaLvl;
            strb.incPtr = ~sdaLvl;
          end else if (sclFall) begin
            cntD = '0;
            if (mAckQ) begin
              stateD = S_RD;
              strb.loadTx = 1'b1;
            end else begin
              stateD = S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      cntQ    <= '0;
      rxQ     <= '0;
      isReadQ <= 1'b0;
      mAckQ   <= 1'b0;
    end else begin
      stateQ  <= stateD;
      cntQ    <= cntD;
      rxQ     <= rxD;
      isReadQ <= isReadD;
      mAckQ   <= mAckD;
    end
  end

  assign rxByte = rxQ;
  assign sdaOe  = (stateQ == S_ADDR_ACK) || (stateQ == S_PTR_ACK) ||
                  (stateQ == S_WR_ACK) || (stateQ == S_RD && !txBit);
endmodule

// File: rtl/rtcI2cData.sv
module rtcI2cData
  import rtcI2cPkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int PTR_W = $clog2(NUM_REGS),
  localparam int TIME_REGS = NUM_REGS - 1,
  localparam int SNAP_W = 8 * TIME_REGS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [7:0]        rxByte,
  input  logic [SNAP_W-1:0] liveTime,
  output logic              txBit,
  output logic              wrEn,
  output logic [PTR_W-1:0]  wrAddr,
  output logic [7:0]        wrData,
  output logic [7:0]        calOut,
  output logic [PTR_W-1:0]  ptrQ,
  output logic              frozen,
  output logic [SNAP_W-1:0] snapView
);
  localparam logic [PTR_W-1:0] CAL_IDX = PTR_W'(TIME_REGS);

  logic [7:0] calQ, txQ, rdByte;
  logic readSess;

  assign frozen = readSess && (ptrQ != CAL_IDX);

  for (genvar g = 0; g < TIME_REGS; g++) begin : gSnap
    logic [7:0] byteQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       byteQ <= '0;
      else if (!frozen) byteQ <= liveTime[8*g +: 8];
    end
    assign snapView[8*g +: 8] = byteQ;
  end

  always_comb begin
    rdByte = calQ;
    for (int i = 0; i < TIME_REGS; i++) begin
      if (ptrQ == PTR_W'(i)) rdByte = snapView[8*i +: 8] & usedBits(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ     <= '0;
      calQ     <= '0;
      txQ      <= 8'hFF;
      readSess <= 1'b0;
    end else begin
      if (strb.loadPtr)                    ptrQ <= rxByte[PTR_W-1:0];
      else if (strb.wrByte || strb.incPtr) ptrQ <= ptrQ + 1'b1;
      if (strb.wrByte && ptrQ == CAL_IDX)  calQ <= rxByte & usedBits(TIME_REGS);
      if (strb.loadTx)       txQ <= rdByte;
      else if (strb.shiftTx) txQ <= {txQ[6:0], 1'b1};
      if (strb.beginRead)    readSess <= 1'b1;
      else if (strb.endRead) readSess <= 1'b0;
    end
  end

  assign txBit  = txQ[7];
  assign wrEn   = strb.wrByte && (ptrQ != CAL_IDX);
  assign wrAddr = ptrQ;
  assign wrData = rxByte & usedBits(int'(ptrQ));
  assign calOut = calQ;
endmodule

// File: rtl/rtcI2cRegs.sv
module rtcI2cRegs
  import rtcI2cPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NUM_REGS = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W = $clog2(NUM_REGS),
  localparam int SNAP_W = 8 * (NUM_REGS - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [SNAP_W-1:0] liveTime,
  output logic              wrEn,
  output logic [PTR_W-1:0]  wrAddr,
  output logic [7:0]        wrData,
  output logic [7:0]        calOut
);
  logic sclLvl, sdaLvl, sclRise, sclFall, startEv, stopEv, txBit, frozen;
  logic [7:0] rxByte;
  logic [PTR_W-1:0] ptrQ;
  logic [SNAP_W-1:0] snapView;
  ctlStrb_t strb;

  rtcI2cSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  rtcI2cCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .sclRise(sclRise),
    .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv), .txBit(txBit),
    .strb(strb), .rxByte(rxByte), .sdaOe(sdaOe)
  );

  rtcI2cData #(.NUM_REGS(NUM_REGS)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte), .liveTime(liveTime),
    .txBit(txBit), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .calOut(calOut), .ptrQ(ptrQ), .frozen(frozen), .snapView(snapView)
  );
endmodule

// File: rtl/rtcI2cChk.sv
module rtcI2cChk #(
  parameter int PTR_W = 3,
  parameter int SNAP_W = 56
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclLvl,
  input logic              sclFall,
  input logic              sdaOe,
  input logic              wrEn,
  input logic [PTR_W-1:0]  wrAddr,
  input logic [PTR_W-1:0]  ptrQ,
  input logic              frozen,
  input logic [SNAP_W-1:0] snapView
);
  // R8
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLvl);

  // R4
  drive_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(sclFall));

  // R2
  wr_time_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrAddr != {PTR_W{1'b1}});

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ptrQ == $past(wrAddr) + 1'b1);

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    frozen |=> $stable(snapView));
endmodule

bind rtcI2cRegs rtcI2cChk #(.PTR_W(PTR_W), .SNAP_W(SNAP_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sclFall(sclFall), .sdaOe(sdaOe),
  .wrEn(wrEn), .wrAddr(wrAddr), .ptrQ(ptrQ), .frozen(frozen), .snapView(snapView)
);

// File: tb/rtcI2cRegs_tb.sv
module rtcI2cRegs_tb;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaOe, wrEn;
  logic [2:0] wrAddr;
  logic [7:0] wrData, calOut;
  logic [55:0] liveTime;
  logic sdaLine;

  int checks = 0, errors = 0;
  bit done = 0;
  int qa[$], qd[$];

  localparam logic [55:0] LIVE_A = 56'hFF_FF_FF_FF_FF_FF_FF;
  localparam logic [55:0] LIVE_B = 56'h21_09_31_06_23_45_12;
  localparam logic [55:0] LIVE_C = 56'h22_10_01_07_13_59_58;

  always #5 clk = ~clk;
  assign sdaLine = sdaDrv & ~sdaOe;

  rtcI2cRegs u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .liveTime(liveTime), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .calOut(calOut)
  );

  // readable bits per location, as stated in R7
  function automatic logic [7:0] keep(input int i);
    case (i)
      2: keep = 8'h3F; 3: keep = 8'h07; 4: keep = 8'h3F; 7: keep = 8'h7F;
      default: keep = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] expTime(input logic [55:0] v, input int i);
    expTime = v[8*i +: 8] & keep(i);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  // reference of expected time-location writes, compared on every clock
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      if (qa.size() == 0) begin
        chk(1'b0, "R2 unexpected write strobe", {wrAddr, wrData}, 0);
      end else begin
        int a, d;
        a = qa.pop_front();
        d = qd.pop_front();
        chk(wrAddr == a[2:0] && wrData == d[7:0], "R2/R7 write strobe",
            {wrAddr, wrData}, {a[2:0], d[7:0]});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    sdaDrv = 1'b0; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick(Q);
    sclDrv = 1'b1; tick(Q);
    sdaDrv = 1'b1; tick(Q);
  endtask

  task automatic wb(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; tick(Q);
      sclDrv = 1'b1; tick(2*Q);
      sclDrv = 1'b0;
    end
    sdaDrv = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    acked = ~sdaLine;
    tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic rb(input bit ackIt, output logic [7:0] b);
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      sclDrv = 1'b1; tick(Q);
      b[i] = sdaLine;
      tick(Q);
      sclDrv = 1'b0;
    end
    sdaDrv = ~ackIt; tick(Q);
    sclDrv = 1'b1; tick(2*Q);
    sclDrv = 1'b0; tick(Q);
    sdaDrv = 1'b1;
  endtask

  task automatic setPtr(input logic [7:0] p);
    bit ak;
    busStart(); wb(8'hD0, ak); chkEq("R1 write address ack", ak, 1);
    wb(p, ak); chkEq("R3 pointer byte ack", ak, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] rd;
    liveTime = LIVE_A;
    tick(5);
    rstN = 1'b1;
    tick(3);
    // R9 reset state
    chkEq("R9 sdaOe after reset", sdaOe, 0);
    chkEq("R9 calOut after reset", calOut, 8'h00);
    chkEq("R9 wrEn after reset", wrEn, 0);

    // R7 calibration write, top bit forced low
    setPtr(8'h07);
    wb(8'hFF, ak); chkEq("R3 data byte ack", ak, 1);
    busStop();
    chkEq("R7 calOut masked", calOut, 8'h7F);
    chkEq("R8 released after stop", sdaOe, 0);

    // R2 burst write with wrap 7 -> 0
    qa.push_back(5); qd.push_back(8'h11);
    qa.push_back(6); qd.push_back(8'h22);
    qa.push_back(0); qd.push_back(8'h8A);
    setPtr(8'h05);
    wb(8'h11, ak); chkEq("R3 ack loc5", ak, 1);
    wb(8'h22, ak); chkEq("R3 ack loc6", ak, 1);
    wb(8'h33, ak); chkEq("R3 ack loc7", ak, 1);
    wb(8'h8A, ak); chkEq("R3 ack after wrap", ak, 1);
    busStop();
    chkEq("R2 cal written at location 7", calOut, 8'h33);
    chkEq("R2 all expected writes seen", qa.size(), 0);

    // R7 masking on a time write; pointer ends at 4
    qa.push_back(3); qd.push_back(8'h07);
    setPtr(8'h03);
    wb(8'hFF, ak);
    busStop();
    chkEq("R7 masked write consumed", qa.size(), 0);

    // R1 foreign address: no ack, following bytes ignored
    busStart();
    wb(8'hA0, ak); chkEq("R1 foreign address not acked", ak, 0);
    wb(8'h01, ak); chkEq("R1 byte after foreign address ignored", ak, 0);
    wb(8'h5C, ak); chkEq("R1 second byte ignored", ak, 0);
    busStop();

    // R5 current-address read: pointer still 4, live = A
    busStart(); wb(8'hD1, ak); chkEq("R1 read address ack", ak, 1);
    rb(1'b0, rd); chkEq("R5 current address read loc4", rd, expTime(LIVE_A, 4));
    chkEq("R4 released after nack", sdaOe, 0);
    busStop();
    // R4 nack does not advance
    busStart(); wb(8'hD1, ak);
    rb(1'b1, rd); chkEq("R4 loc4 again after nack", rd, expTime(LIVE_A, 4));
    rb(1'b0, rd); chkEq("R4 loc5 after ack", rd, expTime(LIVE_A, 5));
    busStop();
    busStart(); wb(8'hD1, ak);
    rb(1'b0, rd); chkEq("R4 pointer held at 5", rd, expTime(LIVE_A, 5));
    busStop();

    // R6 freeze during burst read, with repeated start
    setPtr(8'h00);
    busStart(); wb(8'hD1, ak); chkEq("R8 repeated start address ack", ak, 1);
    rb(1'b1, rd); chkEq("R6 loc0 value A", rd, expTime(LIVE_A, 0));
    liveTime = LIVE_B;
    for (int i = 1; i < 4; i++) begin
      rb(1'b1, rd); chkEq("R6 frozen byte keeps value A", rd, expTime(LIVE_A, i));
    end
    rb(1'b0, rd); chkEq("R6 frozen loc4", rd, expTime(LIVE_A, 4));
    busStop();
    setPtr(8'h00);
    busStart(); wb(8'hD1, ak);
    for (int i = 0; i < 3; i++) begin
      rb(1'b1, rd); chkEq("R6 snapshot follows after stop", rd, expTime(LIVE_B, i));
    end
    rb(1'b0, rd); chkEq("R7 masked loc3 read", rd, expTime(LIVE_B, 3));
    busStop();

    // R6 thaw at location 7, wrap back to 0
    setPtr(8'h06);
    busStart(); wb(8'hD1, ak);
    rb(1'b1, rd); chkEq("R6 loc6 value B", rd, expTime(LIVE_B, 6));
    liveTime = LIVE_C;
    rb(1'b1, rd); chkEq("R7 cal read masked", rd, 8'h33);
    rb(1'b0, rd); chkEq("R6 loc0 after wrap shows C", rd, expTime(LIVE_C, 0));
    busStop();
    chkEq("R8 idle after stop", sdaOe, 0);
    chkEq("R2 no stray writes", qa.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule